// File: doc/BRIEF.md
# Interrupt Event History Buffer

This block keeps a trace of interrupt activity for a processor core. Every time the interrupt controller updates its pending bits, the set bits of that update mark the interrupt ids that were raised, and the block stores the current cycle count as the raise time of each such id. When the core takes an interrupt, the block writes a record into a circular buffer. The record holds the interrupt id, the cycle at which it was taken, and the raise time stored earlier for that id. A free-running count tracks takes and explicit software raises.

For debugging, each id carries a 2-bit stop mode. The block pulses a halt output when a raise or a take matches the mode of its id. A readout port indexes the buffer backwards from the newest record. For each step it returns the record together with its latency (take minus raise) and the gap to the next newer take. It reports the first never-written slot as invalid, which is where a walk through the buffer ends.

Top module: `int_event_history`

## Requirements
- R1: In a cycle where bit k of `raise_set` is 1, the value of `cycle_now` is stored as the raise time of id k. A take of id k in a later cycle records that stored value.
- R2: In a cycle where `take_en` is 1, a record holding `take_id`, `cycle_now` as the take time, and the stored raise time of `take_id` is written to the slot at the write index.
- R3: The write index advances by one after each write and goes back to 0 after slot DEPTH-1. After more than DEPTH takes, only the newest DEPTH records remain.
- R4: Readout step i (`rd_index` = i) returns the slot at (write index - i - 1) mod DEPTH. Step 0 is the newest record. A slot whose take time is 0 gives `rd_valid` = 0.
- R5: `rd_latency` equals take time minus raise time, modulo 2^32. For steps i > 0, `rd_gap_valid` = 1 and `rd_gap` equals the take time of step i-1 minus the take time of step i. For step 0, and for any invalid step, `rd_gap_valid` = 0.
- R6: `raise_total` goes up by 1 for each cycle with `take_en` and by 1 for each cycle with `soft_raise`, so by 2 when both are high in the same cycle. `raise_set` alone leaves it unchanged.
- R7: The stop mode of each id is written through `mode_we`/`mode_id`/`mode_val`. Bit 0 means stop on raise and bit 1 means stop on take. `halt` is 1 in the cycle after a raise or take whose id has the matching mode bit set, and 0 otherwise.
- R8: Synchronous reset clears all records, all stop modes, the write index and `raise_total`.
- R9: The readout outputs are registered. They reflect `rd_index` and the buffer contents as sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_now | input | 32 | Current core cycle count |
| raise_set | input | 8 | Set bits of a pending update, one bit per id |
| soft_raise | input | 1 | Explicit software raise, counted only |
| take_en | input | 1 | An interrupt is taken this cycle |
| take_id | input | 3 | Id of the taken interrupt |
| mode_we | input | 1 | Write a stop mode |
| mode_id | input | 3 | Id whose stop mode is written |
| mode_val | input | 2 | Stop mode: bit 0 on raise, bit 1 on take |
| rd_index | input | 4 | Readout step counted back from newest |
| rd_valid | output | 1 | Addressed slot holds a record |
| rd_id | output | 3 | Id of the record |
| rd_take_cycle | output | 32 | Take time of the record |
| rd_latency | output | 32 | Take time minus raise time |
| rd_gap_valid | output | 1 | `rd_gap` is meaningful |
| rd_gap | output | 32 | Newer take time minus this take time |
| raise_total | output | 16 | Count of takes and soft raises |
| halt | output | 1 | Breakpoint pulse |

## Verification
If the write index is wrong, step 0 shows the wrong id or take time on the first read after the next take. A wrong raise stamp appears as a wrong latency in the record of the next take of that id. The bench reads back several steps after sequences that are shorter and longer than the buffer, so that both wrap and stop-at-empty are seen at the outputs. If a mode bit is stuck, `halt` shows it one cycle after the matching or non-matching event.

// File: rtl/ihb_pkg.sv
package ihb_pkg;
    localparam int CYC_W   = 32;
    localparam int ID_W    = 3;
    localparam int NUM_IDS = 1 << ID_W;

    typedef logic [CYC_W-1:0] cyc_t;
    typedef logic [ID_W-1:0]  id_t;

    typedef struct packed {
        id_t  id;
        cyc_t raised;
        cyc_t taken;
    } rec_t;

    typedef enum logic [1:0] {
        STOP_NONE  = 2'b00,
        STOP_RAISE = 2'b01,
        STOP_TAKE  = 2'b10,
        STOP_BOTH  = 2'b11
    } stop_t;

    // slot that lies 'back' places behind the write index, modulo depth
    function automatic int slot_back(input int wr, input int back, input int depth);
        return (wr + depth - (back % depth)) % depth;
    endfunction
endpackage

// File: rtl/ihb_stamp.sv
module ihb_stamp
    import ihb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  cyc_t               cycle_now,
    input  logic [NUM_IDS-1:0] raise_set,
    input  logic               take_en,
    input  id_t                take_id,
    input  logic               mode_we,
    input  id_t                mode_id,
    input  logic [1:0]         mode_val,
    output cyc_t               take_raised,
    output logic               halt
);
    cyc_t               stamp_q [NUM_IDS];
    stop_t              mode_q  [NUM_IDS];
    logic [NUM_IDS-1:0] raise_hit;
    logic               halt_d;

    genvar g;
    generate
        for (g = 0; g < NUM_IDS; g++) begin : g_id
            always_ff @(posedge clk) begin
                if (rst) begin
                    stamp_q[g] <= '0;
                    mode_q[g]  <= STOP_NONE;
                end else begin
                    if (raise_set[g])
                        stamp_q[g] <= cycle_now;
                    if (mode_we && mode_id == id_t'(g))
                        mode_q[g] <= stop_t'(mode_val);
                end
            end
            assign raise_hit[g] = raise_set[g] && mode_q[g][0];

            a_r1_stamp: assert property (@(posedge clk) disable iff (rst)
                raise_set[g] |=> stamp_q[g] == $past(cycle_now));
        end
    endgenerate

    assign take_raised = stamp_q[take_id];
    assign halt_d      = (|raise_hit) || (take_en && mode_q[take_id][1]);

    always_ff @(posedge clk) begin
        if (rst) halt <= 1'b0;
        else     halt <= halt_d;
    end

    a_r7_halt_cause: assert property (@(posedge clk) disable iff (rst)
        halt |-> $past(take_en || (raise_set != '0)));
endmodule

// File: rtl/ihb_ring.sv
module ihb_ring
    import ihb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take_en,
    input  id_t              take_id,
    input  cyc_t             cycle_now,
    input  cyc_t             take_raised,
    output rec_t             recs [DEPTH],
    output logic [IDX_W-1:0] wr_idx
);
    logic [IDX_W-1:0] wr_next;

    assign wr_next = (int'(wr_idx) == DEPTH - 1) ? '0 : wr_idx + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx <= '0;
        end else if (take_en) begin
            wr_idx <= wr_next;
        end
    end

    genvar s;
    generate
        for (s = 0; s < DEPTH; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    recs[s] <= '0;
                end else if (take_en && int'(wr_idx) == s) begin
                    recs[s].id     <= take_id;
                    recs[s].raised <= take_raised;
                    recs[s].taken  <= cycle_now;
                end
            end
        end
    endgenerate

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !take_en |=> $stable(wr_idx));
    a_r2_write: assert property (@(posedge clk) disable iff (rst)
        take_en |=> recs[$past(wr_idx)].taken == $past(cycle_now));
    a_r3_range: assert property (@(posedge clk) disable iff (rst)
        int'(wr_idx) < DEPTH);
endmodule

// File: rtl/ihb_reader.sv
module ihb_reader
    import ihb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  rec_t             recs [DEPTH],
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IDX_W-1:0] rd_index,
    output logic             rd_valid,
    output id_t              rd_id,
    output cyc_t             rd_take_cycle,
    output cyc_t             rd_latency,
    output logic             rd_gap_valid,
    output cyc_t             rd_gap
);
    rec_t cur, newer;
    logic in_range, cur_ok;

    always_comb begin
        in_range = int'(rd_index) < DEPTH;
        cur      = recs[slot_back(int'(wr_idx), int'(rd_index) + 1, DEPTH)];
        newer    = recs[slot_back(int'(wr_idx), int'(rd_index), DEPTH)];
        cur_ok   = in_range && (cur.taken != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid      <= 1'b0;
            rd_id         <= '0;
            rd_take_cycle <= '0;
            rd_latency    <= '0;
            rd_gap_valid  <= 1'b0;
            rd_gap        <= '0;
        end else begin
            rd_valid      <= cur_ok;
            rd_id         <= cur_ok ? cur.id : '0;
            rd_take_cycle <= cur_ok ? cur.taken : '0;
            rd_latency    <= cur_ok ? cur.taken - cur.raised : '0;
            rd_gap_valid  <= cur_ok && (rd_index != '0);
            rd_gap        <= (cur_ok && rd_index != '0) ? newer.taken - cur.taken : '0;
        end
    end

    a_r5_gap_needs_valid: assert property (@(posedge clk) disable iff (rst)
        rd_gap_valid |-> rd_valid);
    a_r4_empty_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> rd_take_cycle == '0);
endmodule

// File: rtl/int_event_history.sv
module int_event_history
    import ihb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CYC_W-1:0]   cycle_now,
    input  logic [NUM_IDS-1:0] raise_set,
    input  logic               soft_raise,
    input  logic               take_en,
    input  logic [ID_W-1:0]    take_id,
    input  logic               mode_we,
    input  logic [ID_W-1:0]    mode_id,
    input  logic [1:0]         mode_val,
    input  logic [IDX_W-1:0]   rd_index,
    output logic               rd_valid,
    output logic [ID_W-1:0]    rd_id,
    output logic [CYC_W-1:0]   rd_take_cycle,
    output logic [CYC_W-1:0]   rd_latency,
    output logic               rd_gap_valid,
    output logic [CYC_W-1:0]   rd_gap,
    output logic [CNT_W-1:0]   raise_total,
    output logic               halt
);
    cyc_t             take_raised;
    rec_t             recs [DEPTH];
    logic [IDX_W-1:0] wr_idx;

    ihb_stamp u_stamp (
        .clk(clk), .rst(rst), .cycle_now(cycle_now), .raise_set(raise_set),
        .take_en(take_en), .take_id(take_id), .mode_we(mode_we),
        .mode_id(mode_id), .mode_val(mode_val),
        .take_raised(take_raised), .halt(halt)
    );

    ihb_ring #(.DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst(rst), .take_en(take_en), .take_id(take_id),
        .cycle_now(cycle_now), .take_raised(take_raised),
        .recs(recs), .wr_idx(wr_idx)
    );

    ihb_reader #(.DEPTH(DEPTH)) u_reader (
        .clk(clk), .rst(rst), .recs(recs), .wr_idx(wr_idx), .rd_index(rd_index),
        .rd_valid(rd_valid), .rd_id(rd_id), .rd_take_cycle(rd_take_cycle),
        .rd_latency(rd_latency), .rd_gap_valid(rd_gap_valid), .rd_gap(rd_gap)
    );

    always_ff @(posedge clk) begin
        if (rst)
            raise_total <= '0;
        else
            raise_total <= raise_total + CNT_W'(take_en) + CNT_W'(soft_raise);
    end

    a_r6_idle_count: assert property (@(posedge clk) disable iff (rst)
        !(take_en || soft_raise) |=> $stable(raise_total));
    a_r6_single_step: assert property (@(posedge clk) disable iff (rst)
        (take_en ^ soft_raise) |=> raise_total == $past(raise_total) + 1'b1);
endmodule

// File: tb/test_int_event_history.sv
`timescale 1ns/1ps
module test_int_event_history;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] cycle_now;
    logic [7:0]  raise_set;
    logic        soft_raise, take_en, mode_we;
    logic [2:0]  take_id, mode_id;
    logic [1:0]  mode_val;
    logic [3:0]  rd_index;
    logic        rd_valid, rd_gap_valid, halt;
    logic [2:0]  rd_id;
    logic [31:0] rd_take_cycle, rd_latency, rd_gap;
    logic [15:0] raise_total;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    int_event_history #(.DEPTH(DEPTH), .CNT_W(16)) i_int_event_history (
        .clk(clk), .rst(rst), .cycle_now(cycle_now), .raise_set(raise_set),
        .soft_raise(soft_raise), .take_en(take_en), .take_id(take_id),
        .mode_we(mode_we), .mode_id(mode_id), .mode_val(mode_val),
        .rd_index(rd_index), .rd_valid(rd_valid), .rd_id(rd_id),
        .rd_take_cycle(rd_take_cycle), .rd_latency(rd_latency),
        .rd_gap_valid(rd_gap_valid), .rd_gap(rd_gap),
        .raise_total(raise_total), .halt(halt)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        raise_set = '0; soft_raise = 0; take_en = 0; mode_we = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; idle();
        @(negedge clk); @(negedge clk);
        rst = 0;
    endtask

    task automatic raise(input int id, input int cyc);
        @(negedge clk);
        raise_set = 8'(1 << id); cycle_now = 32'(cyc);
        @(negedge clk);
        idle();
    endtask

    task automatic take(input int id, input int cyc);
        @(negedge clk);
        take_en = 1; take_id = 3'(id); cycle_now = 32'(cyc);
        @(negedge clk);
        idle();
    endtask

    task automatic set_mode(input int id, input int m);
        @(negedge clk);
        mode_we = 1; mode_id = 3'(id); mode_val = 2'(m);
        @(negedge clk);
        idle();
    endtask

    // rd_index applied at a falling edge, result one rising edge later (R9)
    task automatic read_step(input int i);
        rd_index = 4'(i);
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        check("R8", "reset raise_total", raise_total, 0);
        check("R8", "reset halt", halt, 0);
        read_step(0);
        check("R8", "reset step0 invalid", rd_valid, 0);
    endtask

    task automatic t_record_and_read();
        raise(2, 100);
        take(2, 130);
        read_step(0);
        check("R9", "step0 valid after one cycle", rd_valid, 1);
        check("R2", "step0 id", rd_id, 2);
        check("R2", "step0 take", rd_take_cycle, 130);
        check("R1", "step0 latency", rd_latency, 30);
        check("R5", "step0 gap_valid", rd_gap_valid, 0);
        raise(5, 200);
        take(5, 260);
        read_step(0);
        check("R4", "newest id", rd_id, 5);
        check("R5", "newest latency", rd_latency, 60);
        read_step(1);
        check("R4", "step1 id", rd_id, 2);
        check("R5", "step1 gap_valid", rd_gap_valid, 1);
        check("R5", "step1 gap", rd_gap, 130);
        read_step(2);
        check("R4", "step2 empty stops", rd_valid, 0);
        check("R5", "step2 gap_valid", rd_gap_valid, 0);
    endtask

    task automatic t_count();
        logic [15:0] c0;
        c0 = raise_total;
        @(negedge clk); soft_raise = 1;
        @(negedge clk); idle();
        check("R6", "soft raise +1", raise_total, 64'(c0 + 1));
        @(negedge clk); soft_raise = 1; take_en = 1; take_id = 1; cycle_now = 400;
        @(negedge clk); idle();
        check("R6", "take+soft +2", raise_total, 64'(c0 + 3));
        raise(1, 410);
        check("R6", "raise_set not counted", raise_total, 64'(c0 + 3));
    endtask

    task automatic t_halt();
        set_mode(3, 1);
        @(negedge clk); raise_set = 8'h08; cycle_now = 500;
        @(negedge clk); idle();
        check("R7", "raise id3 mode1 halts", halt, 1);
        @(negedge clk);
        check("R7", "halt is a pulse", halt, 0);
        @(negedge clk); take_en = 1; take_id = 3; cycle_now = 520;
        @(negedge clk); idle();
        check("R7", "take id3 mode1 no halt", halt, 0);
        set_mode(4, 2);
        @(negedge clk); take_en = 1; take_id = 4; cycle_now = 540;
        @(negedge clk); idle();
        check("R7", "take id4 mode2 halts", halt, 1);
        @(negedge clk); raise_set = 8'h10; cycle_now = 550;
        @(negedge clk); idle();
        check("R7", "raise id4 mode2 no halt", halt, 0);
        set_mode(6, 3);
        @(negedge clk); raise_set = 8'h40; cycle_now = 560;
        @(negedge clk); idle();
        check("R7", "raise id6 mode3 halts", halt, 1);
    endtask

    task automatic t_reset_clears();
        do_reset();
        check("R8", "count cleared", raise_total, 0);
        read_step(0);
        check("R8", "records cleared", rd_valid, 0);
        @(negedge clk); raise_set = 8'h08; cycle_now = 600;
        @(negedge clk); idle();
        check("R8", "mode cleared no halt", halt, 0);
    endtask

    task automatic t_wrap();
        do_reset();
        for (int k = 0; k < DEPTH + 3; k++) take(k % 8, 1000 + k * 10);
        read_step(0);
        check("R3", "wrap newest id", rd_id, 64'((DEPTH + 2) % 8));
        check("R3", "wrap newest take", rd_take_cycle, 64'(1000 + (DEPTH + 2) * 10));
        read_step(DEPTH - 1);
        check("R3", "wrap oldest valid", rd_valid, 1);
        check("R3", "wrap oldest take", rd_take_cycle, 64'(1000 + 3 * 10));
        check("R5", "wrap oldest gap", rd_gap, 10);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1; cycle_now = 0; take_id = 0; mode_id = 0; mode_val = 0; rd_index = 0;
        idle();
        do_reset();
        t_reset_state();
        t_record_and_read();
        t_count();
        t_halt();
        t_reset_clears();
        t_wrap();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule